// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block produces the serial clock for an I2C master from the system clock. A prescaler turns the system clock into a base time unit of 2 × (1 + P) clocks, where P is a 7-bit period value that software writes. Each SCL cycle holds the line low for six base units and then releases it for four. The full period is therefore 20 × (1 + P) system clocks. Standard-mode operation at 100 kbps is reached by writing the P value that gives that rate for the system clock in use.

The surrounding byte engine uses two single-cycle strobes. One marks each falling edge of SCL, where data may change. The other marks the middle of the high phase, where data is sampled. The generator reads back the real SCL line, so a slave that holds SCL low during the high phase stretches that phase. Clearing the enable releases SCL at once and returns every counter to its starting point.

Top module: `scl_pacer`

## Requirements
- R1: After reset, scl_out is 1, fall_stb and samp_stb are 0, and the period register holds 1. Enabling without any write then gives a 24-clock low phase and a 16-clock high phase.
- R2: When en goes high from the disabled state, scl_out goes to 0 on the next rising clock edge, and fall_stb is 1 in that same cycle.
- R3: With no stretching, the low phase lasts exactly 6 × 2 × (1 + P) system clocks.
- R4: With no stretching, the high phase lasts exactly 4 × 2 × (1 + P) system clocks, so each SCL period is 20 × (1 + P) clocks.
- R5: samp_stb pulses for exactly one cycle per high phase. It is the cycle that begins 2 × 2 × (1 + P) clocks after scl_out rises.
- R6: fall_stb pulses for exactly one cycle per SCL cycle. It is high only in the first cycle in which scl_out is 0.
- R7: A period value written while a cycle is in progress leaves that cycle's timing unchanged. The new value applies from the next falling edge of scl_out.
- R8: During the high phase, every clock in which scl_in is 0 while scl_out is 1 adds one clock to the high phase and holds back samp_stb by one clock.
- R9: Clearing en makes scl_out 1, with no strobes, from the next clock on. SCL stays released while disabled. Re-enabling starts a fresh, full-length low phase.
- R10: Example periods: P=2 gives 60 clocks (333 kHz at 20 MHz), P=9 gives 200 clocks (100 kHz at 20 MHz), P=4 gives 100 clocks (400 kHz at 40 MHz), and P=19 gives 400 clocks (100 kHz at 40 MHz). P=0 and P=127 give 20 and 2560 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the generator; when 0, SCL is released and the counters are cleared |
| prd_we | input | 1 | Write strobe for the period register |
| prd_wdata | input | 7 | New period value P |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_out | output | 1 | SCL drive level: 0 pulls the line low, 1 releases it |
| fall_stb | output | 1 | One-cycle strobe on each SCL falling edge |
| samp_stb | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
The assertions assume that scl_in reads 1 for most of each high phase, so that the high phase eventually ends. They also assume that scl_in never reads 1 while scl_out is 0. The bench meets both assumptions by deriving scl_in from scl_out ANDed with a stretch control of its own, and it raises that stretch control only for short windows inside the high phase. The bench changes en and the period write port only between clock edges. It writes the period register either while the block is disabled or at a chosen point in the low phase.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_prd_reg.sv
module scl_prd_reg #(
  parameter int PRD_W   = 7,
  parameter int PRD_RST = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PRD_W-1:0] wdata,
  output logic [PRD_W-1:0] prd_q
);
  always_ff @(posedge clk) begin
    if (rst)     prd_q <= PRD_W'(PRD_RST);
    else if (we) prd_q <= wdata;
  end

  // R1: a write lands in the register one clock later
  a_r1_prd_write: assert property (@(posedge clk) disable iff (rst)
    we |=> prd_q == $past(wdata));
endmodule

// File: rtl/scl_unit_tick.sv
module scl_unit_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          tick
);
  logic [CW-1:0] pcnt;

  assign tick = run && !clr && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (run)    pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R3: the prescaler never runs past its limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    pcnt <= lim);
  // R8: a stalled prescaler keeps its count
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_pacer_pkg::*;
#(
  parameter int PRD_W      = 7,
  parameter int PRD_RST    = 1,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_in,
  input  logic [PRD_W-1:0] prd_q,
  input  logic             tick,
  output logic [PRD_W-1:0] prd_act,
  output logic             clr,
  output logic             run,
  output logic             scl_out,
  output logic             fall_stb,
  output logic             samp_stb
);
  localparam int MAXU = (LOW_UNITS > HIGH_UNITS) ? LOW_UNITS : HIGH_UNITS;
  localparam int UCW  = (MAXU > 1) ? $clog2(MAXU) : 1;
  localparam int HALF = HIGH_UNITS / 2;

  scl_phase_e     state;
  logic [UCW-1:0] ucnt;
  logic           low_done, high_done, start_cyc;

  assign low_done  = tick && (ucnt == UCW'(LOW_UNITS - 1));
  assign high_done = tick && (ucnt == UCW'(HIGH_UNITS - 1));
  assign start_cyc = en && ((state == PH_IDLE) || (state == PH_HIGH && high_done));
  assign clr       = !en || (state == PH_IDLE);
  assign run       = !(state == PH_HIGH && !scl_in);

  always_ff @(posedge clk) begin
    if (rst)            prd_act <= PRD_W'(PRD_RST);
    else if (start_cyc) prd_act <= prd_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= PH_IDLE;
      ucnt     <= '0;
      scl_out  <= 1'b1;
      fall_stb <= 1'b0;
      samp_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      samp_stb <= 1'b0;
      case (state)
        PH_IDLE: begin
          state    <= PH_LOW;
          ucnt     <= '0;
          scl_out  <= 1'b0;
          fall_stb <= 1'b1;
        end
        PH_LOW: begin
          if (low_done) begin
            state   <= PH_HIGH;
            ucnt    <= '0;
            scl_out <= 1'b1;
          end else if (tick) begin
            ucnt <= ucnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            state    <= PH_LOW;
            ucnt     <= '0;
            scl_out  <= 1'b0;
            fall_stb <= 1'b1;
          end else if (tick) begin
            ucnt     <= ucnt + 1'b1;
            samp_stb <= (ucnt == UCW'(HALF - 1));
          end
        end
        default: begin
          state   <= PH_IDLE;
          scl_out <= 1'b1;
        end
      endcase
    end
  end

  // R6: the fall strobe coincides with a high-to-low step of scl_out
  a_r6_fall_edge: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (!scl_out && $past(scl_out)));
  // R5: the sample strobe appears only while SCL is released
  a_r5_samp_high: assert property (@(posedge clk) disable iff (rst)
    samp_stb |-> scl_out);
  // R9: disabling releases SCL and silences the strobes
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_out && !fall_stb && !samp_stb));
  // R7: the active period changes only at the start of an SCL cycle
  a_r7_prd_apply: assert property (@(posedge clk) disable iff (rst)
    !$stable(prd_act) |-> fall_stb);
  // R8: a held-low line freezes the high-phase unit count
  a_r8_stretch: assert property (@(posedge clk) disable iff (rst)
    (en && state == PH_HIGH && !scl_in) |=> $stable(ucnt));
  // R3: the unit count stays within the longer phase
  a_r3_unit_bound: assert property (@(posedge clk) disable iff (rst)
    ucnt < UCW'(MAXU));
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int PRD_W      = 7,
  parameter int PRD_RST    = 1,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             prd_we,
  input  logic [PRD_W-1:0] prd_wdata,
  input  logic             scl_in,
  output logic             scl_out,
  output logic             fall_stb,
  output logic             samp_stb
);
  localparam int CW = PRD_W + 1;

  logic [PRD_W-1:0] prd_q, prd_act;
  logic             tick, clr, run;
  logic [CW-1:0]    lim;

  // one base unit is 2*(1+P) clocks, so the count limit is 2P+1
  assign lim = {prd_act, 1'b1};

  scl_prd_reg #(.PRD_W(PRD_W), .PRD_RST(PRD_RST)) u_prd (
    .clk(clk), .rst(rst), .we(prd_we), .wdata(prd_wdata), .prd_q(prd_q)
  );

  scl_unit_tick #(.CW(CW)) u_tick (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .lim(lim), .tick(tick)
  );

  scl_phase_seq #(
    .PRD_W(PRD_W), .PRD_RST(PRD_RST),
    .LOW_UNITS(LOW_UNITS), .HIGH_UNITS(HIGH_UNITS)
  ) u_seq (
    .clk(clk), .rst(rst), .en(en), .scl_in(scl_in), .prd_q(prd_q),
    .tick(tick), .prd_act(prd_act), .clr(clr), .run(run),
    .scl_out(scl_out), .fall_stb(fall_stb), .samp_stb(samp_stb)
  );
endmodule

// File: tb/tb_scl_pacer.sv
`timescale 1ns/1ps
module tb_scl_pacer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       prd_we = 1'b0;
  logic [6:0] prd_wdata = '0;
  logic       stretch = 1'b0;
  logic       scl_in, scl_out, fall_stb, samp_stb;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;
  assign scl_in = scl_out & ~stretch;

  scl_pacer dut (
    .clk(clk), .rst(rst), .en(en), .prd_we(prd_we), .prd_wdata(prd_wdata),
    .scl_in(scl_in), .scl_out(scl_out), .fall_stb(fall_stb), .samp_stb(samp_stb)
  );

  localparam int NV = 6;
  localparam int VP  [0:NV-1] = '{2, 9, 4, 19, 0, 127};
  localparam int VLO [0:NV-1] = '{36, 120, 60, 240, 12, 1536};
  localparam int VHI [0:NV-1] = '{24, 80, 40, 160, 8, 1024};
  localparam int VS  [0:NV-1] = '{12, 40, 20, 80, 4, 512};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int wr_at, input logic [6:0] wr_val,
                         input int st_at, input int st_len,
                         output int lo, output int hi, output int sidx,
                         output int nfall, output int nsamp);
    int g;
    g = 0;
    while (!fall_stb && g < 20000) begin @(negedge clk); g++; end
    lo = 0; nfall = 0;
    while (scl_out == 1'b0 && lo < 20000) begin
      if (fall_stb) nfall++;
      prd_we = (lo == wr_at);
      prd_wdata = wr_val;
      @(negedge clk);
      lo++;
    end
    prd_we = 1'b0;
    hi = 0; sidx = -1; nsamp = 0;
    while (scl_out == 1'b1 && hi < 20000) begin
      if (samp_stb) begin nsamp++; sidx = hi; end
      stretch = (hi >= st_at) && (hi < st_at + st_len);
      @(negedge clk);
      hi++;
    end
    stretch = 1'b0;
  endtask

  task automatic load_and_start(input int p);
    en = 1'b0;
    @(negedge clk);
    prd_we = 1'b1; prd_wdata = 7'(p);
    @(negedge clk);
    prd_we = 1'b0; en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int lo, hi, sidx, nf, ns, lowseen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 scl_out after reset", int'(scl_out), 1);
    chk("R1 fall_stb after reset", int'(fall_stb), 0);
    chk("R1 samp_stb after reset", int'(samp_stb), 0);

    // R2: enable pulls SCL low with a fall strobe
    en = 1'b1;
    @(negedge clk);
    chk("R2 scl_out low on enable", int'(scl_out), 0);
    chk("R2 fall_stb on enable", int'(fall_stb), 1);
    // R1: reset period value 1
    measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
    chk("R1 low with reset period", lo, 24);
    chk("R1 high with reset period", hi, 16);

    // vector table: R3, R4, R5, R6, R10
    for (int i = 0; i < NV; i++) begin
      load_and_start(VP[i]);
      measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
      chk("R3 R10 low phase", lo, VLO[i]);
      chk("R4 R10 high phase", hi, VHI[i]);
      chk("R5 sample position", sidx, VS[i]);
      chk("R5 one sample strobe", ns, 1);
      chk("R6 one fall strobe", nf, 1);
      measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
      chk("R4 R10 full period", lo + hi, VLO[i] + VHI[i]);
    end

    // R7: write P=0 during a P=2 low phase
    load_and_start(2);
    measure(5, 7'd0, -1, 0, lo, hi, sidx, nf, ns);
    chk("R7 current low unchanged", lo, 36);
    chk("R7 current high unchanged", hi, 24);
    measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
    chk("R7 next low uses new value", lo, 12);
    chk("R7 next high uses new value", hi, 8);

    // R8: stretch 5 clocks early in the high phase at P=0
    measure(-1, '0, 2, 5, lo, hi, sidx, nf, ns);
    chk("R8 low not affected", lo, 12);
    chk("R8 high extended", hi, 13);
    chk("R8 sample delayed", sidx, 9);

    // R9: disable in the middle of a low phase
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 released after disable", int'(scl_out), 1);
    chk("R9 no fall strobe after disable", int'(fall_stb), 0);
    lowseen = 0;
    repeat (10) begin
      @(negedge clk);
      if (!scl_out || fall_stb || samp_stb) lowseen++;
    end
    chk("R9 stays released while disabled", lowseen, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 restart fall strobe", int'(fall_stb), 1);
    measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
    chk("R9 fresh low phase", lo, 12);

    // R1: reset mid-run restores period 1
    rst = 1'b1; en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_out after second reset", int'(scl_out), 1);
    en = 1'b1;
    @(negedge clk);
    measure(-1, '0, -1, 0, lo, hi, sidx, nf, ns);
    chk("R1 period restored low", lo, 24);
    chk("R1 period restored high", hi, 16);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule